// File: doc/BRIEF.md
# Signed Multiply/Divide Unit with HI/LO Result Pair

This block performs signed 32-bit multiplication and division as a multi-cycle side unit next to an integer datapath. A start command carries two operands and an operation select. The block then runs a bit-serial loop for one operand width of cycles. The result lands in a dedicated pair of result registers, HI and LO, that sit apart from the general register file. For a multiply, HI takes the upper half of the 64-bit product and LO the lower half. For a divide, LO takes the quotient and HI the remainder.

Both loops work on operand magnitudes, and the signs are applied in the same edge that writes HI and LO. Division truncates toward zero, as integer division does in C. A zero divisor completes in the normal time with a fixed result and does not stall. The pipeline reads HI or LO through one read port, choosing between them with a select line. Busy is the only interlock, and a start that arrives while busy is dropped.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, busy_o and done_o are low and both HI and LO read as zero.
- R2: A start_i sampled high while busy_o is low is accepted. busy_o is then high for exactly 32 cycles. done_o is high for exactly one cycle, the first cycle after busy_o falls, and the new HI/LO values are readable in that same cycle.
- R3: With op_div_i = 0 (multiply), both operands are treated as two's complement and the full 64-bit signed product is stored: bits 63..32 in HI and bits 31..0 in LO.
- R4: With op_div_i = 1 (divide), LO receives the quotient truncated toward zero and HI receives a remainder that is zero or has the sign of the dividend, such that quotient × divisor + remainder equals the dividend.
- R5: A divide by zero completes in the normal 32 cycles with LO = 32'hFFFFFFFF and HI equal to the dividend.
- R6: A start_i pulse while busy_o is high is ignored: the operation in flight keeps its operands, its operation and its cycle count.
- R7: rd_data_o shows HI when rd_hi_i = 1 and LO when rd_hi_i = 0, in the same cycle. HI and LO change only at the completion of an operation.
- R8: Dividing the most negative value (32'h80000000) by -1 wraps: LO = 32'h80000000 and HI = 0. Multiplying 32'h80000000 by itself gives HI = 32'h40000000 and LO = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, used only while idle |
| op_div_i | input | 1 | Operation: 0 multiply, 1 divide |
| opa_i | input | 32 | Multiplicand or dividend (signed) |
| opb_i | input | 32 | Multiplier or divisor (signed) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_hi_i | input | 1 | Read select: 1 HI, 0 LO |
| rd_data_o | output | 32 | Selected result register |

## Verification
The multiply vectors cover every pairing of operand signs, a product that carries exactly into HI, and the largest positive and negative magnitudes. Together they show whether the sign is applied across all 64 bits and whether the carry out of the add-shift step is kept. The divide vectors cover each of the four sign pairings of 7 by 2, which separates truncation toward zero from flooring and shows which operand's sign the remainder takes. Further vectors cover a dividend smaller than its divisor, zero divisors with both dividend signs, and the overflowing minimum-value divide. A start fired in the middle of a busy operation with different operands shows whether the operation in flight is disturbed.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } md_op_e;

  function automatic logic [31:0] mag32(input logic [31:0] v);
    return v[31] ? (~v + 32'd1) : v;
  endfunction
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl #(
  parameter int W = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic step_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  assign accept_o = start_i && !busy_q;
  assign step_o   = busy_q;
  assign last_o   = busy_q && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_o) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/muldiv_step.sv
// One radix-2 iteration: shift-add multiply or restoring divide.
// acc holds {upper, lower}; mul: {partial, multiplier}, div: {rem, dividend/quotient}.
module muldiv_step #(
  parameter int W = 32
) (
  input  muldiv_pkg::md_op_e op_i,
  input  logic [2*W-1:0]     acc_i,
  input  logic [W-1:0]       m_i,
  output logic [2*W-1:0]     acc_o
);
  import muldiv_pkg::*;

  logic [W:0] mul_sum;
  logic [W:0] div_r;
  logic [W:0] div_diff;
  logic       div_ok;

  always_comb begin
    mul_sum  = {1'b0, acc_i[2*W-1:W]} + (acc_i[0] ? {1'b0, m_i} : '0);
    div_r    = acc_i[2*W-1:W-1];
    div_diff = div_r - {1'b0, m_i};
    div_ok   = !div_diff[W];
    if (op_i == OP_MUL) begin
      acc_o = {mul_sum, acc_i[W-1:1]};
    end else begin
      acc_o = {(div_ok ? div_diff[W-1:0] : div_r[W-1:0]), acc_i[W-2:0], div_ok};
    end
  end
endmodule

// File: rtl/muldiv_fix.sv
// Applies result signs and the divide-by-zero override.
module muldiv_fix #(
  parameter int W = 32
) (
  input  muldiv_pkg::md_op_e op_i,
  input  logic [2*W-1:0]     acc_i,
  input  logic               neg_a_i,
  input  logic               neg_b_i,
  input  logic               div0_i,
  input  logic [W-1:0]       a_raw_i,
  output logic [W-1:0]       hi_o,
  output logic [W-1:0]       lo_o
);
  import muldiv_pkg::*;

  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, rem;

  always_comb begin
    prod = (neg_a_i ^ neg_b_i) ? (~acc_i + 1'b1) : acc_i;
    quo  = (neg_a_i ^ neg_b_i) ? (~acc_i[W-1:0] + 1'b1) : acc_i[W-1:0];
    rem  = neg_a_i ? (~acc_i[2*W-1:W] + 1'b1) : acc_i[2*W-1:W];
    if (op_i == OP_MUL) begin
      hi_o = prod[2*W-1:W];
      lo_o = prod[W-1:0];
    end else if (div0_i) begin
      hi_o = a_raw_i;
      lo_o = '1;
    end else begin
      hi_o = rem;
      lo_o = quo;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         op_div_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         busy_o,
  output logic         done_o,
  input  logic         rd_hi_i,
  output logic [W-1:0] rd_data_o
);
  import muldiv_pkg::*;

  logic           accept, step, last;
  md_op_e         op_q, op_in;
  logic [2*W-1:0] acc_q, acc_nxt;
  logic [W-1:0]   m_q, a_raw_q;
  logic           neg_a_q, neg_b_q, div0_q;
  logic [W-1:0]   hi_q, lo_q, hi_res, lo_res;
  logic [W-1:0]   a_mag, b_mag;

  assign op_in = op_div_i ? OP_DIV : OP_MUL;
  assign a_mag = opa_i[W-1] ? (~opa_i + 1'b1) : opa_i;
  assign b_mag = opb_i[W-1] ? (~opb_i + 1'b1) : opb_i;

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .step_o  (step),
    .last_o  (last),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  muldiv_step #(.W(W)) u_step (
    .op_i (op_q),
    .acc_i(acc_q),
    .m_i  (m_q),
    .acc_o(acc_nxt)
  );

  muldiv_fix #(.W(W)) u_fix (
    .op_i   (op_q),
    .acc_i  (acc_nxt),
    .neg_a_i(neg_a_q),
    .neg_b_i(neg_b_q),
    .div0_i (div0_q),
    .a_raw_i(a_raw_q),
    .hi_o   (hi_res),
    .lo_o   (lo_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_MUL;
      acc_q   <= '0;
      m_q     <= '0;
      a_raw_q <= '0;
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      div0_q  <= 1'b0;
    end else if (accept) begin
      op_q    <= op_in;
      a_raw_q <= opa_i;
      neg_a_q <= opa_i[W-1];
      neg_b_q <= opb_i[W-1];
      div0_q  <= (opb_i == '0);
      if (op_in == OP_MUL) begin
        acc_q <= {{W{1'b0}}, b_mag};
        m_q   <= a_mag;
      end else begin
        acc_q <= {{W{1'b0}}, a_mag};
        m_q   <= b_mag;
      end
    end else if (step) begin
      acc_q <= acc_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (last) begin
      hi_q <= hi_res;
      lo_q <= lo_res;
    end
  end

  assign rd_data_o = rd_hi_i ? hi_q : lo_q;
endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic         op_div_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  localparam int RW = $clog2(W) + 2;

  logic [RW-1:0]  run_q;
  logic           c_div;
  logic [W-1:0]   c_a, c_b;
  logic [2*W-1:0] c_prod;
  logic [W-1:0]   c_back;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      c_div <= 1'b0;
      c_a   <= '0;
      c_b   <= '0;
    end else begin
      run_q <= busy_o ? run_q + 1'b1 : '0;
      if (start_i && !busy_o) begin
        c_div <= op_div_i;
        c_a   <= opa_i;
        c_b   <= opb_i;
      end
    end
  end

  assign c_prod = {{W{c_a[W-1]}}, c_a} * {{W{c_b[W-1]}}, c_b};
  assign c_back = lo_q * c_b + hi_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o)) else $error("done without busy"); // R2
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_q == RW'(W)) else $error("busy length"); // R2
  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < RW'(W)) else $error("busy too long"); // R6
  AST_MUL_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !c_div |-> {hi_q, lo_q} == c_prod) else $error("product"); // R3
  AST_DIV_IDENTITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && c_div && c_b != '0 |-> c_back == c_a && (hi_q == '0 || hi_q[W-1] == c_a[W-1]))
    else $error("divide identity"); // R4
  AST_DIV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && c_div && c_b == '0 |-> lo_q == '1 && hi_q == c_a) else $error("div by zero"); // R5
  AST_HILO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(hi_q) && $stable(lo_q)) else $error("hi/lo moved"); // R7
endmodule

bind muldiv_unit muldiv_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_div_i(op_div_i),
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hi_q    (hi_q),
  .lo_q    (lo_q)
);

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op_div = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done;
  logic        rd_hi = 1'b0;
  logic [31:0] rd_data;
  int          checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  muldiv_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_div_i(op_div),
    .opa_i(opa), .opb_i(opb), .busy_o(busy), .done_o(done),
    .rd_hi_i(rd_hi), .rd_data_o(rd_data)
  );

  // {op_div, a, b, exp_hi, exp_lo}
  localparam logic [128:0] VEC [0:12] = '{
    {1'b0, 32'h00000007, 32'hFFFFFFFD, 32'hFFFFFFFF, 32'hFFFFFFEB}, // R3
    {1'b0, 32'h00010000, 32'h00010000, 32'h00000001, 32'h00000000}, // R3
    {1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000001}, // R3
    {1'b0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000}, // R8
    {1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h3FFFFFFF, 32'h00000001}, // R3
    {1'b1, 32'h00000007, 32'h00000002, 32'h00000001, 32'h00000003}, // R4
    {1'b1, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD}, // R4
    {1'b1, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD}, // R4
    {1'b1, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000003}, // R4
    {1'b1, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000}, // R8
    {1'b1, 32'h00000005, 32'h00000000, 32'h00000005, 32'hFFFFFFFF}, // R5
    {1'b1, 32'hFFFFFFF7, 32'h00000000, 32'hFFFFFFF7, 32'hFFFFFFFF}, // R5
    {1'b1, 32'h00000003, 32'h0000000A, 32'h00000003, 32'h00000000}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_hl(output logic [31:0] hi, output logic [31:0] lo);
    rd_hi = 1'b1; #1 hi = rd_data;
    rd_hi = 1'b0; #1 lo = rd_data;
  endtask

  // Launches one operation; poke fires a stray start mid-run with other operands.
  task automatic run_op(input logic d, input logic [31:0] a, input logic [31:0] b,
                        input bit poke, output int nbusy, output bit saw_done);
    @(negedge clk);
    start = 1'b1; op_div = d; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0; opa = 32'h5A5A5A5A; opb = 32'h00000003; op_div = ~d;
    nbusy = 0; saw_done = 0;
    for (int i = 0; i < 40; i++) begin
      start = 1'b0;
      if (done) begin saw_done = 1; break; end
      if (busy) nbusy++;
      if (poke && nbusy == 10) start = 1'b1;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] hi, lo;
    int nb;
    bit sd;
    #20;
    @(negedge clk);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    read_hl(hi, lo);
    check("R1 hi", hi, 32'd0);
    check("R1 lo", lo, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    read_hl(hi, lo);
    check("R1 hi after release", hi, 32'd0);

    for (int k = 0; k < 13; k++) begin
      logic [128:0] v;
      v = VEC[k];
      run_op(v[128], v[127:96], v[95:64], 1'b0, nb, sd);
      check("R2 busy cycles", nb, 32'd32);
      check("R2 done seen", {31'b0, sd}, 32'd1);
      read_hl(hi, lo);
      check(v[128] ? "R4/R5/R8 hi" : "R3/R8 hi", hi, v[63:32]);
      check(v[128] ? "R4/R5/R8 lo" : "R3/R8 lo", lo, v[31:0]);
      if (v[128] && v[95:64] != 0)
        check("R4 identity", lo * v[95:64] + hi, v[127:96]);
      @(negedge clk);
      check("R2 done one cycle", {31'b0, done}, 32'd0);
    end

    // R6: stray start while busy must not restart or redirect the op
    run_op(1'b0, 32'hFFFFFF00, 32'h00000100, 1'b1, nb, sd);
    check("R6 busy cycles", nb, 32'd32);
    read_hl(hi, lo);
    check("R6 hi", hi, 32'hFFFFFFFF);
    check("R6 lo", lo, 32'hFFFF0000);
    @(negedge clk);
    check("R6 no second run", {31'b0, busy}, 32'd0);

    // R7: values hold and the read select works in the same cycle
    repeat (5) @(negedge clk);
    opa = 32'h12345678; opb = 32'h1; op_div = 1'b1;
    @(negedge clk);
    read_hl(hi, lo);
    check("R7 hi hold", hi, 32'hFFFFFFFF);
    check("R7 lo hold", lo, 32'hFFFF0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule